// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides, cycle by cycle, which kinds of access an on-chip flash array may accept. It produces four permission flags: plain read, verify-read, program and erase. It tracks a sticky error flag, and it owns the two write-enable bits that start a program or an erase operation. A detected error locks out programming and erasing, but the array stays readable. Only a reset or the hardware standby pin clears that lockout.

The block follows the CPU's low-power transitions. Software standby, subsleep and watch clear the flash control registers on entry, and sleep leaves them alone. Subactive mode keeps plain read only. A sleep request made while a program or erase bit is set counts as an error. While either bit is set, or while the boot loader runs, the block raises a mask that holds off every interrupt, including the non-maskable one.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is 0, and from the first clock edge at which `stby_n` is 0, all four permissions are 0 and the error flag is 0. The first edge with both pins at 1 enters normal mode.
- R2: In normal mode, read, verify-read, program and erase are all 1, and the error flag is 0.
- R3: A one-cycle pulse on any `err_det_i` bit sets the error flag at the next edge. From normal mode it enters error protection, where read and verify-read are 1 and program and erase are 0. From a low-power state it enters the low-power error state, where all four permissions are 0 and the clear strobe pulses.
- R4: Only `rst_n` or `stby_n` clears the error flag. Low-power entry and release keep it.
- R5: `lp_req_i` in normal mode with P or E set and a mode other than subactive sets the error flag. All four permissions go to 0 and `regs_clr_o` is 1 for the first cycle.
- R6: `lp_req_i` in normal mode with P or E set and mode 4 (subactive) sets the error flag and enters error protection. `regs_clr_o` stays 0.
- R7: `lp_req_i` in normal mode with P and E clear and mode 0 (software standby), 2 (subsleep) or 3 (watch) turns all permissions off and pulses `regs_clr_o` for one cycle. Mode 1 (sleep) turns them off without the pulse.
- R8: `lp_req_i` in normal mode with P and E clear and mode 4 (subactive) leaves only read at 1. `regs_clr_o` stays 0.
- R9: `lp_exit_i` in a low-power state returns to normal mode if the error flag is 0, or to error protection if it is 1.
- R10: A write (`pe_we_i`) updates P only while program permission is 1, and E only while erase permission is 1. Either bit reads 0 one cycle after its permission drops.
- R11: `irq_mask_o` is 1 exactly when P, E or `boot_run_i` is 1.
- R12: `lp_req_i` in error protection, with any mode, turns all permissions off. It keeps the error flag and pulses `regs_clr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_n | input | 1 | Hardware standby, active low, sampled at the clock |
| lp_req_i | input | 1 | Low-power entry request, one-cycle pulse |
| lp_mode_i | input | 3 | Requested mode: 0 standby, 1 sleep, 2 subsleep, 3 watch, 4 subactive |
| lp_exit_i | input | 1 | Low-power release, one-cycle pulse |
| err_det_i | input | ERR_SRC_N | Error-detect pulses, one per source |
| boot_run_i | input | 1 | Boot loader is executing |
| pe_we_i | input | 1 | Write strobe for the P and E bits |
| p_wdata_i | input | 1 | Write value for P |
| e_wdata_i | input | 1 | Write value for E |
| rd_ok_o | output | 1 | Plain read permitted |
| vf_ok_o | output | 1 | Verify-read permitted |
| pr_ok_o | output | 1 | Programming permitted |
| er_ok_o | output | 1 | Erasing permitted |
| err_flag_o | output | 1 | Sticky error flag |
| regs_clr_o | output | 1 | Strobe clearing the flash control and block-enable registers |
| p_bit_o | output | 1 | Program bit |
| e_bit_o | output | 1 | Erase bit |
| irq_mask_o | output | 1 | Mask for all CPU interrupts, NMI included |

## Verification
The assertions assume that `lp_req_i`, `lp_exit_i` and `err_det_i` arrive as single-cycle pulses. They also assume that `lp_mode_i` holds a code from 0 to 4 whenever a request is made. The bench always lowers each pulse after one cycle, uses only those five mode codes, and never raises a request and a release in the same cycle. Each sweep case starts from a standby pulse, so no state carries over between cases.

// File: rtl/fg_pkg.sv
package fg_pkg;
   localparam int LP_MODE_W = 3;

   typedef enum logic [2:0] {
      ST_HW    = 3'd0,
      ST_NORM  = 3'd1,
      ST_ERR   = 3'd2,
      ST_LP    = 3'd3,
      ST_SUB   = 3'd4,
      ST_LPERR = 3'd5
   } fg_state_t;

   localparam logic [LP_MODE_W-1:0] MODE_SLEEP  = 3'd1;
   localparam logic [LP_MODE_W-1:0] MODE_SUBACT = 3'd4;

   typedef struct packed {
      logic rd;
      logic vf;
      logic pr;
      logic er;
   } fg_perm_t;

   function automatic fg_perm_t perm_of(fg_state_t s);
      fg_perm_t p;
      p = '0;
      case (s)
         ST_NORM: p = '{rd: 1'b1, vf: 1'b1, pr: 1'b1, er: 1'b1};
         ST_ERR:  p = '{rd: 1'b1, vf: 1'b1, pr: 1'b0, er: 1'b0};
         ST_SUB:  p = '{rd: 1'b1, vf: 1'b0, pr: 1'b0, er: 1'b0};
         default: p = '0;
      endcase
      return p;
   endfunction
endpackage

// File: rtl/fg_mode_fsm.sv
module fg_mode_fsm
   import fg_pkg::*;
#(
   parameter int ERR_SRC_N    = 2,
   parameter bit CLR_ON_SLEEP = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stby_n,
   input  logic                 lp_req_i,
   input  logic [LP_MODE_W-1:0] lp_mode_i,
   input  logic                 lp_exit_i,
   input  logic [ERR_SRC_N-1:0] err_det_i,
   input  logic                 pe_busy_i,
   output fg_state_t            state_o,
   output logic                 err_o,
   output logic                 clr_o
);
   fg_state_t st_q, st_d;
   logic      err_q, err_d, clr_q, clr_d;
   logic      err_any, sleep_clr;

   assign err_any = |err_det_i;

   generate
      if (ERR_SRC_N < 1) begin : g_bad_src
         $error("fg_mode_fsm: ERR_SRC_N must be at least 1");
      end
      if (CLR_ON_SLEEP) begin : g_sleep_clr
         assign sleep_clr = 1'b1;
      end else begin : g_sleep_keep
         assign sleep_clr = (lp_mode_i != MODE_SLEEP);
      end
   endgenerate

   always_comb begin
      st_d  = st_q;
      err_d = err_q;
      clr_d = 1'b0;
      if (!stby_n) begin
         st_d  = ST_HW;
         err_d = 1'b0;
      end else begin
         case (st_q)
            ST_HW: st_d = ST_NORM;
            ST_NORM: begin
               if (err_any) begin
                  st_d  = ST_ERR;
                  err_d = 1'b1;
               end else if (lp_req_i) begin
                  if (pe_busy_i) begin
                     err_d = 1'b1;
                     if (lp_mode_i == MODE_SUBACT) begin
                        st_d = ST_ERR;
                     end else begin
                        st_d  = ST_LPERR;
                        clr_d = 1'b1;
                     end
                  end else if (lp_mode_i == MODE_SUBACT) begin
                     st_d = ST_SUB;
                  end else begin
                     st_d  = ST_LP;
                     clr_d = sleep_clr;
                  end
               end
            end
            ST_ERR: begin
               if (lp_req_i) begin
                  st_d  = ST_LPERR;
                  clr_d = 1'b1;
               end
            end
            ST_LP, ST_SUB: begin
               if (err_any) begin
                  st_d  = ST_LPERR;
                  err_d = 1'b1;
                  clr_d = 1'b1;
               end else if (lp_exit_i) begin
                  st_d = ST_NORM;
               end
            end
            ST_LPERR: if (lp_exit_i) st_d = ST_ERR;
            default:  st_d = ST_HW;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_HW;
         err_q <= 1'b0;
         clr_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         err_q <= err_d;
         clr_q <= clr_d;
      end
   end

   assign state_o = st_q;
   assign err_o   = err_q;
   assign clr_o   = clr_q;

   // R1
   hw_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stby_n |=> (st_q == ST_HW && !err_q));
   // R4
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && stby_n) |=> err_q);
   // R7
   clr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |-> (st_q == ST_LP || st_q == ST_LPERR));
endmodule

// File: rtl/fg_pe_bits.sv
module fg_pe_bits #(
   parameter int N_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic [N_BITS-1:0] ok_i,
   input  logic              we_i,
   input  logic [N_BITS-1:0] wdata_i,
   output logic [N_BITS-1:0] bits_o
);
   generate
      if (N_BITS < 1) begin : g_bad_n
         $error("fg_pe_bits: N_BITS must be at least 1");
      end
      for (genvar g = 0; g < N_BITS; g++) begin : g_bit
         logic b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          b_q <= 1'b0;
            else if (clr_i)      b_q <= 1'b0;
            else if (!ok_i[g])   b_q <= 1'b0;
            else if (we_i)       b_q <= wdata_i[g];
         end
         assign bits_o[g] = b_q;

         // R10
         lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ok_i[g] |=> !b_q);
      end
   endgenerate
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import fg_pkg::*;
#(
   parameter int ERR_SRC_N    = 2,
   parameter bit CLR_ON_SLEEP = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stby_n,
   input  logic                 lp_req_i,
   input  logic [2:0]           lp_mode_i,
   input  logic                 lp_exit_i,
   input  logic [ERR_SRC_N-1:0] err_det_i,
   input  logic                 boot_run_i,
   input  logic                 pe_we_i,
   input  logic                 p_wdata_i,
   input  logic                 e_wdata_i,
   output logic                 rd_ok_o,
   output logic                 vf_ok_o,
   output logic                 pr_ok_o,
   output logic                 er_ok_o,
   output logic                 err_flag_o,
   output logic                 regs_clr_o,
   output logic                 p_bit_o,
   output logic                 e_bit_o,
   output logic                 irq_mask_o
);
   localparam int PE_N = 2;

   fg_state_t       state;
   fg_perm_t        perm;
   logic            err, clr;
   logic [PE_N-1:0] pe_bits;

   fg_mode_fsm #(.ERR_SRC_N(ERR_SRC_N), .CLR_ON_SLEEP(CLR_ON_SLEEP)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .stby_n    (stby_n),
      .lp_req_i  (lp_req_i),
      .lp_mode_i (lp_mode_i),
      .lp_exit_i (lp_exit_i),
      .err_det_i (err_det_i),
      .pe_busy_i (|pe_bits),
      .state_o   (state),
      .err_o     (err),
      .clr_o     (clr)
   );

   assign perm = perm_of(state);

   fg_pe_bits #(.N_BITS(PE_N)) u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .ok_i    ({perm.er, perm.pr}),
      .we_i    (pe_we_i),
      .wdata_i ({e_wdata_i, p_wdata_i}),
      .bits_o  (pe_bits)
   );

   assign rd_ok_o    = perm.rd;
   assign vf_ok_o    = perm.vf;
   assign pr_ok_o    = perm.pr;
   assign er_ok_o    = perm.er;
   assign err_flag_o = err;
   assign regs_clr_o = clr;
   assign p_bit_o    = pe_bits[0];
   assign e_bit_o    = pe_bits[1];
   assign irq_mask_o = (|pe_bits) | boot_run_i;

   // R3
   err_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag_o |-> (!pr_ok_o && !er_ok_o));
   // R12
   clr_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      regs_clr_o |-> !(rd_ok_o || vf_ok_o || pr_ok_o || er_ok_o));
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
   localparam int NSRC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0, stby_n = 1'b1, lp_req = 1'b0, lp_exit = 1'b0;
   logic [2:0] lp_mode = 3'd0;
   logic [NSRC-1:0] err_det = '0;
   logic boot = 1'b0, pe_we = 1'b0, p_wd = 1'b0, e_wd = 1'b0;
   logic rd, vf, pr, er, errf, clr, pb, eb, irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flash_guard #(.ERR_SRC_N(NSRC)) u_flash_guard (
      .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .lp_req_i(lp_req),
      .lp_mode_i(lp_mode), .lp_exit_i(lp_exit), .err_det_i(err_det),
      .boot_run_i(boot), .pe_we_i(pe_we), .p_wdata_i(p_wd), .e_wdata_i(e_wd),
      .rd_ok_o(rd), .vf_ok_o(vf), .pr_ok_o(pr), .er_ok_o(er),
      .err_flag_o(errf), .regs_clr_o(clr), .p_bit_o(pb), .e_bit_o(eb),
      .irq_mask_o(irq)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [5:0] obs();
      return {rd, vf, pr, er, errf, clr};
   endfunction

   task automatic standby_pulse();
      stby_n = 1'b0;
      tick();
      stby_n = 1'b1;
      tick();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      tick();
      chk("R1 reset", obs(), 6'b0000_00);
      chk("R11 reset mask", {5'b0, irq}, 6'b0);
      rst_n = 1'b1;
      tick();
      // R2
      chk("R2 normal", obs(), 6'b1111_00);

      for (int m = 0; m < 5; m++) begin
         for (int ef = 0; ef < 2; ef++) begin
            for (int pe = 0; pe < 3; pe++) begin
               logic [5:0] exp_lp;
               bit e_now, busy;
               string tag;
               standby_pulse();
               chk("R1 standby exit", obs(), 6'b1111_00);
               if (ef == 1) begin
                  err_det = NSRC'(1) << (m % NSRC);
                  tick();
                  err_det = '0;
                  chk("R3 error prot", obs(), 6'b1100_10);
               end
               if (pe != 0) begin
                  pe_we = 1'b1;
                  p_wd = (pe == 1);
                  e_wd = (pe == 2);
                  tick();
                  pe_we = 1'b0;
                  busy = (ef == 0);
                  chk("R10 write", {4'b0, pb, eb},
                      {4'b0, busy && pe == 1, busy && pe == 2});
                  chk("R11 mask", {5'b0, irq}, {5'b0, busy});
               end else begin
                  busy = 1'b0;
               end
               lp_mode = 3'(m);
               lp_req = 1'b1;
               tick();
               lp_req = 1'b0;
               if (ef == 1) begin
                  exp_lp = 6'b0000_11; tag = "R12 lp from err"; e_now = 1'b1;
               end else if (busy) begin
                  e_now = 1'b1;
                  if (m == 4) begin exp_lp = 6'b1100_10; tag = "R6 subact busy"; end
                  else        begin exp_lp = 6'b0000_11; tag = "R5 sleep busy"; end
               end else begin
                  e_now = 1'b0;
                  if (m == 4)      begin exp_lp = 6'b1000_00; tag = "R8 subactive"; end
                  else if (m == 1) begin exp_lp = 6'b0000_00; tag = "R7 sleep"; end
                  else             begin exp_lp = 6'b0000_01; tag = "R7 lp clear"; end
               end
               chk(tag, obs(), exp_lp);
               tick();
               chk("R7 strobe drop", {5'b0, clr}, 6'b0);
               chk("R10 forced off", {4'b0, pb, eb}, 6'b0);
               lp_exit = 1'b1;
               tick();
               lp_exit = 1'b0;
               chk("R9 release", obs(), e_now ? 6'b1100_10 : 6'b1111_00);
               chk("R4 flag kept", {5'b0, errf}, {5'b0, e_now});
            end
         end
      end

      // R3: error while in low power
      standby_pulse();
      lp_mode = 3'd0;
      lp_req = 1'b1;
      tick();
      lp_req = 1'b0;
      err_det = NSRC'(2);
      tick();
      err_det = '0;
      chk("R3 err in lp", obs(), 6'b0000_11);
      // R4: only standby clears the flag
      stby_n = 1'b0;
      tick();
      chk("R4 standby clears", obs(), 6'b0000_00);
      stby_n = 1'b1;
      tick();
      // R11: boot run masks interrupts
      boot = 1'b1;
      #1;
      chk("R11 boot mask", {5'b0, irq}, 6'b1);
      boot = 1'b0;
      #1;
      chk("R11 boot off", {5'b0, irq}, 6'b0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule